// File: doc/BRIEF.md
# Bank-Sliced Low-Activity RAM

This block presents a 4096-word by 4-bit synchronous memory with a separate write port and read port. Behind that interface the storage is split into banks of equal size, each of fixed 4096-bit capacity. In the default horizontal arrangement every bank is as wide as the logical word. The upper address bits pick the single bank that is clocked on an access, and the rest stay idle. A registered select then steers the read data of the chosen bank to the output.

A parameter switches to a vertical arrangement for comparison. In that arrangement each bank holds one bit of every word over the full address range, so every bank is clocked on every access. A second parameter sets the bank depth, and through it the number of banks; the output mux may have at most four ways. A running count of bank activations shows the cost of each arrangement on the same traffic.

Top module: `banked_ram`

## Requirements
- R1: While rst_n is low and right after it rises, rd_data reads 0 and act_count reads 0.
- R2: A word written at any address is returned unchanged by a later read of that address, including addresses on both sides of a bank boundary.
- R3: Read data appears on rd_data at the first rising edge after the edge that samples rd_req high. rd_data holds its value through every cycle in which rd_req is low.
- R4: In horizontal mode each write and each read enables exactly one bank, the bank number being wr_addr[11:10] or rd_addr[11:10] (default depth 1024), and act_count rises by 1 for each such access.
- R5: A cycle with neither wr_req nor rd_req enables no bank and leaves act_count unchanged.
- R6: In vertical mode every write and every read enables all four 4096x1 banks, and act_count rises by 4 per access.
- R7: A read and a write to the same address in the same cycle return the content held before that write.
- R8: A write and a read in the same cycle are counted separately: +2 in horizontal mode, +8 in vertical mode.
- R9: Addresses that differ only in bits [11:10] map to different banks and do not disturb each other's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of output register, select and counter |
| wr_req | input | 1 | Write request |
| wr_addr | input | 12 | Write word address |
| wr_data | input | 4 | Write word |
| rd_req | input | 1 | Read request |
| rd_addr | input | 12 | Read word address |
| rd_data | output | 4 | Read word, one cycle after the request |
| act_count | output | 16 | Wrapping count of bank activations |

## Verification
The bench builds two copies side by side. One uses the default horizontal arrangement with 1024-word banks, so there are four banks and a four-way mux. The other uses the vertical arrangement with four 4096x1 banks. Both receive the same traffic and are compared against one reference array. Running the same stimulus through both makes the activation deltas of 1 and 4 per access, and 2 and 8 for combined cycles, directly comparable. Writes that differ only in the bank-select bits, together with a simultaneous read and write on one address, cover the decoder and the read-before-write ordering.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
   typedef enum logic { SLICE_HORIZ = 1'b0, SLICE_VERT = 1'b1 } slice_e;
   localparam int MAX_MUX_WAYS = 4;
   localparam int PRIM_BITS    = 4096;
endpackage

// File: rtl/bsr_bank.sv
`timescale 1ns/1ps
module bsr_bank #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ce,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_ce,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_q
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_ce) cells[wr_addr] <= wr_data;
   end

   // read-first: nonblocking read sees the value before a same-edge write
   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_ce) rd_q <= cells[rd_addr];
   end
endmodule

// File: rtl/bsr_decoder.sv
`timescale 1ns/1ps
module bsr_decoder #(
   parameter int SEL_W = 2,
   localparam int NB   = 2**SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [NB-1:0]    ce
);
   always_comb begin
      ce = '0;
      if (en) ce[sel] = 1'b1;
   end
endmodule

// File: rtl/bsr_out_mux.sv
`timescale 1ns/1ps
module bsr_out_mux #(
   parameter int SEL_W = 2,
   parameter int WIDTH = 4,
   localparam int NB   = 2**SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_req,
   input  logic [SEL_W-1:0]    rd_sel,
   input  logic [NB*WIDTH-1:0] bank_q,
   output logic [WIDTH-1:0]    rd_data
);
   logic [SEL_W-1:0] sel_q;
   logic [WIDTH-1:0] lanes [NB];

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (rd_req) sel_q <= rd_sel;
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign lanes[i] = bank_q[i*WIDTH +: WIDTH];
   end

   assign rd_data = lanes[sel_q];
endmodule

// File: rtl/bsr_act_counter.sv
`timescale 1ns/1ps
module bsr_act_counter #(
   parameter int NB    = 4,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NB-1:0]    wr_ce,
   input  logic [NB-1:0]    rd_ce,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + CNT_W'($countones(wr_ce)) + CNT_W'($countones(rd_ce));
   end
endmodule

// File: rtl/banked_ram.sv
`timescale 1ns/1ps
module banked_ram #(
   parameter int              ADDR_W     = 12,
   parameter int              WORD_W     = 4,
   parameter int              BANK_DEPTH = 1024,
   parameter int              CNT_W      = 16,
   parameter bsr_pkg::slice_e SLICING    = bsr_pkg::SLICE_HORIZ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]  act_count
);
   import bsr_pkg::*;

   localparam int  WORDS = 2**ADDR_W;
   localparam bit  VERT  = (SLICING == SLICE_VERT);
   localparam int  NB    = VERT ? WORD_W : WORDS / BANK_DEPTH;
   localparam int  LOW_W = $clog2(BANK_DEPTH);
   localparam int  SEL_W = (ADDR_W > LOW_W) ? ADDR_W - LOW_W : 1;

   logic [NB-1:0] wr_ce, rd_ce;

   if (VERT) begin : g_vert
      if (WORDS != PRIM_BITS) begin : g_bad_depth
         $error("vertical slicing needs a 1-bit bank spanning the whole address range");
      end
      assign wr_ce = {NB{wr_req}};
      assign rd_ce = {NB{rd_req}};
      for (genvar b = 0; b < NB; b++) begin : g_bank
         bsr_bank #(.DEPTH(WORDS), .WIDTH(1)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_ce(wr_ce[b]), .wr_addr(wr_addr), .wr_data(wr_data[b]),
            .rd_ce(rd_ce[b]), .rd_addr(rd_addr), .rd_q(rd_data[b]));
      end
   end else begin : g_horiz
      if (BANK_DEPTH * WORD_W != PRIM_BITS) begin : g_bad_shape
         $error("bank shape must fill the fixed bank capacity");
      end
      if (2**LOW_W != BANK_DEPTH) begin : g_bad_pow2
         $error("bank depth must be a power of two");
      end
      if (NB < 2 || NB > MAX_MUX_WAYS) begin : g_bad_ways
         $error("bank count must lie between two and the mux limit");
      end

      logic [NB*WORD_W-1:0] bank_q;

      bsr_decoder #(.SEL_W(SEL_W)) u_wr_dec (
         .en(wr_req), .sel(wr_addr[ADDR_W-1:LOW_W]), .ce(wr_ce));
      bsr_decoder #(.SEL_W(SEL_W)) u_rd_dec (
         .en(rd_req), .sel(rd_addr[ADDR_W-1:LOW_W]), .ce(rd_ce));

      for (genvar b = 0; b < NB; b++) begin : g_bank
         bsr_bank #(.DEPTH(BANK_DEPTH), .WIDTH(WORD_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_ce(wr_ce[b]), .wr_addr(wr_addr[LOW_W-1:0]), .wr_data(wr_data),
            .rd_ce(rd_ce[b]), .rd_addr(rd_addr[LOW_W-1:0]),
            .rd_q(bank_q[b*WORD_W +: WORD_W]));
      end

      bsr_out_mux #(.SEL_W(SEL_W), .WIDTH(WORD_W)) u_mux (
         .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
         .rd_sel(rd_addr[ADDR_W-1:LOW_W]), .bank_q(bank_q), .rd_data(rd_data));

      // R4: one bank at most, exactly one when requested
      a_r4_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(wr_ce) && (wr_req -> $countones(wr_ce) == 1));
      a_r4_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(rd_ce) && (rd_req -> $countones(rd_ce) == 1));
      a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_req ^ rd_req) |=> act_count == $past(act_count) + CNT_W'(1));
   end

   bsr_act_counter #(.NB(NB), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .rd_ce(rd_ce), .count(act_count));

   if (VERT) begin : g_vert_chk
      // R6: all banks counted per access
      a_r6_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_req ^ rd_req) |=> act_count == $past(act_count) + CNT_W'(NB));
   end

   // R5: idle cycle leaves the counter alone
   a_r5_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req && !rd_req) |=> $stable(act_count));
   // R3: output holds without a read
   a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));
endmodule

// File: tb/banked_ram_bench.sv
`timescale 1ns/1ps
module banked_ram_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0, rd_req = 1'b0;
   logic [11:0] wr_addr = '0, rd_addr = '0;
   logic [3:0]  wr_data = '0;
   logic [3:0]  rd_h, rd_v;
   logic [15:0] cnt_h, cnt_v;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   banked_ram u_banked_ram (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_h), .act_count(cnt_h));

   banked_ram #(.SLICING(bsr_pkg::SLICE_VERT)) u_banked_ram_vert (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_v), .act_count(cnt_v));

   logic [3:0] ref_mem [4096];
   logic [3:0] last_rd;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // fields: wr, wr_addr, wr_data, rd, rd_addr
   localparam int NV = 20;
   localparam logic [29:0] VEC [NV] = '{
      {1'b1, 12'h000, 4'h5, 1'b0, 12'h000},
      {1'b1, 12'h400, 4'hA, 1'b0, 12'h000},   // R9 same low bits, bank 1
      {1'b1, 12'h800, 4'h3, 1'b0, 12'h000},
      {1'b1, 12'hC00, 4'hC, 1'b0, 12'h000},
      {1'b1, 12'h401, 4'h1, 1'b0, 12'h000},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'h000},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'h400},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'h800},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'hC00},
      {1'b0, 12'h000, 4'h0, 1'b0, 12'h000},   // idle R5, hold R3
      {1'b1, 12'h3FF, 4'h7, 1'b1, 12'h400},   // R8 combined
      {1'b0, 12'h000, 4'h0, 1'b1, 12'h3FF},   // R2 bank boundary
      {1'b1, 12'h401, 4'h9, 1'b1, 12'h401},   // R7 old data
      {1'b0, 12'h000, 4'h0, 1'b1, 12'h401},
      {1'b1, 12'hFFF, 4'hE, 1'b0, 12'h000},
      {1'b0, 12'h000, 4'h0, 1'b0, 12'h000},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'hFFF},
      {1'b1, 12'hBFF, 4'h6, 1'b1, 12'h000},
      {1'b0, 12'h000, 4'h0, 1'b1, 12'hBFF},
      {1'b0, 12'h000, 4'h0, 1'b0, 12'h000}
   };

   task automatic step(input bit w, input logic [11:0] wa, input logic [3:0] wd,
                       input bit r, input logic [11:0] ra);
      logic [15:0] h0, v0;
      logic [3:0]  exp;
      h0 = cnt_h; v0 = cnt_v;
      wr_req = w; wr_addr = wa; wr_data = wd; rd_req = r; rd_addr = ra;
      exp = r ? ref_mem[ra] : last_rd;
      if (w) ref_mem[wa] = wd;
      @(negedge clk);
      wr_req = 1'b0; rd_req = 1'b0;
      if (r && w && wa == ra)
         check(rd_h === exp && rd_v === exp, "R7", int'(rd_h), int'(exp));
      else if (r)
         check(rd_h === exp && rd_v === exp, "R2", int'(rd_h), int'(exp));
      else
         check(rd_h === exp && rd_v === exp, "R3", int'(rd_h), int'(exp));
      last_rd = exp;
      if (!w && !r)
         check(cnt_h == h0 && cnt_v == v0, "R5", int'(cnt_h - h0), 0);
      else if (w && r) begin
         check(16'(cnt_h - h0) == 16'd2, "R8", int'(16'(cnt_h - h0)), 2);
         check(16'(cnt_v - v0) == 16'd8, "R8", int'(16'(cnt_v - v0)), 8);
      end else begin
         check(16'(cnt_h - h0) == 16'd1, "R4", int'(16'(cnt_h - h0)), 1);
         check(16'(cnt_v - v0) == 16'd4, "R6", int'(16'(cnt_v - v0)), 4);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      last_rd = 4'h0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(rd_h == 0 && rd_v == 0, "R1", int'(rd_h), 0);
      check(cnt_h == 0 && cnt_v == 0, "R1", int'(cnt_h), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_h == 0 && rd_v == 0 && cnt_h == 0 && cnt_v == 0, "R1",
            int'(cnt_h), 0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][29], VEC[i][28:17], VEC[i][16:13], VEC[i][12], VEC[i][11:0]);
      end

      // R9: bank-select-only differences keep separate words
      for (int k = 0; k < 4; k++) begin
         step(1'b1, {2'(k), 10'h155}, 4'(k + 8), 1'b0, 12'h000);
      end
      for (int k = 3; k >= 0; k--) begin
         step(1'b0, 12'h000, 4'h0, 1'b1, {2'(k), 10'h155});
         check(rd_h == 4'(k + 8), "R9", int'(rd_h), k + 8);
      end

      // R2: sweep stride through the whole range
      for (int k = 0; k < 16; k++) begin
         step(1'b1, 12'(k * 256 + 17), 4'(15 - k), 1'b0, 12'h000);
      end
      for (int k = 0; k < 16; k++) begin
         step(1'b0, 12'h000, 4'h0, 1'b1, 12'(k * 256 + 17));
      end

      // R3: several idle cycles, output stays put
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 12'h000, 4'h0, 1'b0, 12'h000);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule